// File: doc/BRIEF.md
# SDRAM Bank Activation Timing Guard

This block sits between a memory command source and the command pins of an SDRAM. The source presents one request at a time: a command code, a bank, a row and a column. The guard holds that request until it may legally go out. It then raises a one-cycle grant and drives the command, bank and address from registers. The guard tracks four banks. Each bank is either idle or has one row open.

Three activation windows are enforced together:
- activate to first read or write of the same bank;
- activate to activate within one bank;
- activate to activate across any two banks.

Each window is given in picoseconds. At elaboration it is turned into whole clock cycles by ceiling division with the clock period. With the default figures, a 20 ns access delay on a 7.5 ns clock gives 3 cycles, the reopen window gives 9 cycles and the cross-bank gap gives 2 cycles.

A read or write aimed at an idle bank is a protocol fault. It is never granted, and it sets a sticky error flag. An activate aimed at a bank whose row is still open is simply held until a precharge closes that row. Refresh, mode programming, data-path timing and burst transfers are not part of this block.

Top module: `act_timing_guard`

## Requirements
- R1: While reset is high and on the first cycle after it, `grant` is 0, `cmd_out` is NOP (3'b000), `bank_out` and `addr_out` are 0 and `proto_err` is 0.
- R2: Each window in cycles is ceil(time_ps / TCK_PS); with TRCD_PS=20000 and TCK_PS=7500 the activate-to-access window is exactly 3 cycles.
- R3: A read (3'b010) or write (3'b011) to bank b is granted no earlier than RCD cycles after the grant of the activate (3'b001) that opened bank b, and exactly RCD cycles after it when nothing else blocks it.
- R4: Two activates to the same bank are granted at least RC cycles apart, and exactly RC apart when the bank was precharged earlier and no other window blocks.
- R5: Any two activates, to any banks, are granted at least RRD cycles apart, and exactly RRD apart when no other window blocks.
- R6: An activate to a bank whose row is open is held with `grant` low for as long as the request stands; after a precharge (3'b100) to that bank it is granted.
- R7: A read or write to an idle bank is never granted; it sets `proto_err`, which stays 1 until reset. Held activates do not set it.
- R8: In every cycle without a grant, `cmd_out` is NOP; a request with code NOP or an unused code (3'b101 to 3'b111) is never granted.
- R9: On a grant, `cmd_out` and `bank_out` carry the request's code and bank. `addr_out` carries the row for an activate, the zero-extended column for a read or write, and 0 for a precharge.
- R10: A request is granted on the first clock edge at which it is legal: the grant appears one cycle after the request is presented, if it is legal then. A precharge is always legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented and held until granted |
| req_cmd | input | 3 | Request code: NOP 000, ACT 001, RD 010, WR 011, PRE 100 |
| req_bank | input | 2 | Target bank |
| req_row | input | 12 | Row number for an activate |
| req_col | input | 10 | Column number for a read or write |
| grant | output | 1 | One-cycle strobe: the command on the outputs is issued this cycle |
| cmd_out | output | 3 | Driven command code, NOP when there is no grant |
| bank_out | output | 2 | Driven bank |
| addr_out | output | 12 | Driven address: row, column or zero |
| proto_err | output | 1 | Sticky flag for an access to an idle bank |

## Verification
A stale window counter moves a grant edge. The bench compares every grant cycle against the arithmetic earliest cycle, so such a fault shows as an early or late `grant` on the very cycle concerned. A wrong open flag has one of two effects: a held activate is released, or a legal access never comes out. Either shows within one request, because the bench bounds how long each request may wait. A modelled command sequence drives all four banks through many openings and closings, so a fault that needs a particular bank interleaving is reached as well.

// File: rtl/act_guard_pkg.sv
`timescale 1ns/1ps
package act_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;

  // whole cycles covering a time window, rounded up
  function automatic int unsigned cycles_for(input int unsigned span_ps,
                                             input int unsigned tck_ps);
    return (span_ps + tck_ps - 1) / tck_ps;
  endfunction

  // counter preload so that the window expires on the right edge
  function automatic int unsigned preload_for(input int unsigned cyc);
    return (cyc > 0) ? cyc - 1 : 0;
  endfunction

endpackage

// File: rtl/act_down_counter.sv
`timescale 1ns/1ps
module act_down_counter #(
  parameter int unsigned LOAD = 2,
  parameter int unsigned W    = $clog2(LOAD + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= W'(LOAD);
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/act_bank_state.sv
`timescale 1ns/1ps
module act_bank_state #(
  parameter int unsigned RCD_LOAD = 2,
  parameter int unsigned RC_LOAD  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic act_fire,
  input  logic pre_fire,
  output logic is_open,
  output logic access_ok,
  output logic reopen_ok
);

  logic rcd_done;
  logic rc_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      is_open <= 1'b0;
    end else if (act_fire) begin
      is_open <= 1'b1;
    end else if (pre_fire) begin
      is_open <= 1'b0;
    end
  end

  act_down_counter #(.LOAD(RCD_LOAD)) u_rcd (
    .clk(clk), .rst(rst), .load(act_fire), .expired(rcd_done)
  );

  act_down_counter #(.LOAD(RC_LOAD)) u_rc (
    .clk(clk), .rst(rst), .load(act_fire), .expired(rc_done)
  );

  assign access_ok = is_open & rcd_done;
  assign reopen_ok = ~is_open & rc_done;

endmodule

// File: rtl/act_issue_check.sv
`timescale 1ns/1ps
module act_issue_check
  import act_guard_pkg::*;
#(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = $clog2(BANKS)
) (
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [BANKS-1:0]  bank_open,
  input  logic [BANKS-1:0]  bank_access_ok,
  input  logic [BANKS-1:0]  bank_reopen_ok,
  input  logic              gap_ok,
  output logic              fire,
  output logic              idle_access
);

  logic legal;
  logic is_access;

  assign is_access = (req_cmd == CMD_RD) || (req_cmd == CMD_WR);

  always_comb begin
    unique case (req_cmd)
      CMD_ACT: legal = bank_reopen_ok[req_bank] & gap_ok;
      CMD_RD,
      CMD_WR:  legal = bank_access_ok[req_bank];
      CMD_PRE: legal = 1'b1;
      default: legal = 1'b0;
    endcase
  end

  assign fire        = req_valid & legal;
  assign idle_access = req_valid & is_access & ~bank_open[req_bank];

endmodule

// File: rtl/act_timing_guard.sv
`timescale 1ns/1ps
module act_timing_guard
  import act_guard_pkg::*;
#(
  parameter int unsigned BANKS    = 4,
  parameter int unsigned BANK_W   = $clog2(BANKS),
  parameter int unsigned ROW_W    = 12,
  parameter int unsigned COL_W    = 10,
  parameter int unsigned TCK_PS   = 7500,
  parameter int unsigned TRCD_PS  = 20000,
  parameter int unsigned TRC_PS   = 65000,
  parameter int unsigned TRRD_PS  = 15000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_cmd,
  input  logic [BANK_W-1:0] req_bank,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              grant,
  output logic [2:0]        cmd_out,
  output logic [BANK_W-1:0] bank_out,
  output logic [ROW_W-1:0]  addr_out,
  output logic              proto_err
);

  localparam int unsigned RCD_CYC = cycles_for(TRCD_PS, TCK_PS);
  localparam int unsigned RC_CYC  = cycles_for(TRC_PS, TCK_PS);
  localparam int unsigned RRD_CYC = cycles_for(TRRD_PS, TCK_PS);

  logic [BANKS-1:0] bank_open;
  logic [BANKS-1:0] bank_access_ok;
  logic [BANKS-1:0] bank_reopen_ok;
  logic [BANKS-1:0] act_hit;
  logic [BANKS-1:0] pre_hit;
  logic             gap_ok;
  logic             fire;
  logic             idle_access;
  logic             act_fire;

  assign act_fire = fire && (req_cmd == CMD_ACT);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign act_hit[b] = act_fire && (req_bank == BANK_W'(b));
    assign pre_hit[b] = fire && (req_cmd == CMD_PRE) && (req_bank == BANK_W'(b));

    act_bank_state #(
      .RCD_LOAD(preload_for(RCD_CYC)),
      .RC_LOAD (preload_for(RC_CYC))
    ) u_state (
      .clk      (clk),
      .rst      (rst),
      .act_fire (act_hit[b]),
      .pre_fire (pre_hit[b]),
      .is_open  (bank_open[b]),
      .access_ok(bank_access_ok[b]),
      .reopen_ok(bank_reopen_ok[b])
    );
  end

  act_down_counter #(.LOAD(preload_for(RRD_CYC))) u_gap (
    .clk(clk), .rst(rst), .load(act_fire), .expired(gap_ok)
  );

  act_issue_check #(.BANKS(BANKS), .BANK_W(BANK_W)) u_check (
    .req_valid     (req_valid),
    .req_cmd       (req_cmd),
    .req_bank      (req_bank),
    .bank_open     (bank_open),
    .bank_access_ok(bank_access_ok),
    .bank_reopen_ok(bank_reopen_ok),
    .gap_ok        (gap_ok),
    .fire          (fire),
    .idle_access   (idle_access)
  );

  logic [ROW_W-1:0] addr_next;

  always_comb begin
    addr_next = '0;
    if (req_cmd == CMD_ACT) begin
      addr_next = req_row;
    end else if ((req_cmd == CMD_RD) || (req_cmd == CMD_WR)) begin
      addr_next = ROW_W'(req_col);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant     <= 1'b0;
      cmd_out   <= CMD_NOP;
      bank_out  <= '0;
      addr_out  <= '0;
      proto_err <= 1'b0;
    end else begin
      grant     <= fire;
      cmd_out   <= fire ? req_cmd : CMD_NOP;
      bank_out  <= fire ? req_bank : '0;
      addr_out  <= fire ? addr_next : '0;
      proto_err <= proto_err | idle_access;
    end
  end

endmodule

// File: rtl/act_timing_guard_chk.sv
`timescale 1ns/1ps
module act_timing_guard_chk #(
  parameter int unsigned BANKS  = 4,
  parameter int unsigned BANK_W = 2,
  parameter int unsigned RCD    = 3,
  parameter int unsigned RC     = 9,
  parameter int unsigned RRD    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [2:0]        req_cmd,
  input logic [BANK_W-1:0] req_bank,
  input logic              grant,
  input logic [2:0]        cmd_out,
  input logic [BANK_W-1:0] bank_out,
  input logic              proto_err
);

  localparam int unsigned SAT = (RC > RCD ? (RC > RRD ? RC : RRD) : (RCD > RRD ? RCD : RRD));

  logic out_act;
  logic out_pre;
  logic out_acc;
  int unsigned since_any;
  int unsigned since_bank [BANKS];
  logic [BANKS-1:0] open_seen;

  assign out_act = grant && (cmd_out == 3'd1);
  assign out_pre = grant && (cmd_out == 3'd4);
  assign out_acc = grant && ((cmd_out == 3'd2) || (cmd_out == 3'd3));

  always_ff @(posedge clk) begin
    if (rst) begin
      since_any <= SAT;
    end else if (out_act) begin
      since_any <= 1;
    end else if (since_any < SAT) begin
      since_any <= since_any + 1;
    end
  end

  p_idle_nop_r8: assert property (@(posedge clk) disable iff (rst)
    !grant |-> (cmd_out == 3'd0));

  p_grant_follows_req_r10: assert property (@(posedge clk) disable iff (rst)
    grant |-> ($past(req_valid) && (cmd_out == $past(req_cmd)) && (bank_out == $past(req_bank))));

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    $past(proto_err) |-> proto_err);

  p_act_gap_r5: assert property (@(posedge clk) disable iff (rst)
    out_act |-> (since_any >= RRD));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        since_bank[b] <= SAT;
        open_seen[b]  <= 1'b0;
      end else begin
        if (out_act && (bank_out == BANK_W'(b))) begin
          since_bank[b] <= 1;
          open_seen[b]  <= 1'b1;
        end else begin
          if (since_bank[b] < SAT) since_bank[b] <= since_bank[b] + 1;
          if (out_pre && (bank_out == BANK_W'(b))) open_seen[b] <= 1'b0;
        end
      end
    end

    p_access_delay_r3: assert property (@(posedge clk) disable iff (rst)
      (out_acc && (bank_out == BANK_W'(b))) |-> (since_bank[b] >= RCD));

    p_reopen_delay_r4: assert property (@(posedge clk) disable iff (rst)
      (out_act && (bank_out == BANK_W'(b))) |-> (since_bank[b] >= RC));

    p_act_needs_closed_r6: assert property (@(posedge clk) disable iff (rst)
      (out_act && (bank_out == BANK_W'(b))) |-> !open_seen[b]);

    p_access_needs_open_r7: assert property (@(posedge clk) disable iff (rst)
      (out_acc && (bank_out == BANK_W'(b))) |-> open_seen[b]);
  end

endmodule

bind act_timing_guard act_timing_guard_chk #(
  .BANKS (BANKS),
  .BANK_W(BANK_W),
  .RCD   (RCD_CYC),
  .RC    (RC_CYC),
  .RRD   (RRD_CYC)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_cmd  (req_cmd),
  .req_bank (req_bank),
  .grant    (grant),
  .cmd_out  (cmd_out),
  .bank_out (bank_out),
  .proto_err(proto_err)
);

// File: tb/tb_act_timing_guard.sv
`timescale 1ns/1ps
module tb_act_timing_guard;

  localparam int TCK  = 7500;
  localparam int TRCD = 20000;
  localparam int TRC  = 65000;
  localparam int TRRD = 15000;
  localparam int RCD_E = (TRCD + TCK - 1) / TCK;
  localparam int RC_E  = (TRC + TCK - 1) / TCK;
  localparam int RRD_E = (TRRD + TCK - 1) / TCK;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [2:0]  req_cmd = 3'd0;
  logic [1:0]  req_bank = 2'd0;
  logic [11:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        grant;
  logic [2:0]  cmd_out;
  logic [1:0]  bank_out;
  logic [11:0] addr_out;
  logic        proto_err;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  int last_act [4];
  int last_any;
  bit open_m [4];

  act_timing_guard dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .grant(grant), .cmd_out(cmd_out), .bank_out(bank_out),
    .addr_out(addr_out), .proto_err(proto_err)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // present a request, wait at most limit edges for its grant; gedge = -1 if none
  task automatic send(input int c, input int b, input int row, input int col,
                      input int limit, output int gedge);
    req_cmd = 3'(c); req_bank = 2'(b); req_row = 12'(row); req_col = 10'(col);
    req_valid = 1'b1;
    gedge = -1;
    for (int i = 0; i < limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (grant) begin
        gedge = cyc;
        break;
      end
    end
    req_valid = 1'b0;
    if (gedge >= 0) begin
      int ea;
      ea = (c == 1) ? row : ((c == 2 || c == 3) ? col : 0);
      check(cmd_out == 3'(c), "R9 cmd", int'(cmd_out), c);
      check(bank_out == 2'(b), "R9 bank", int'(bank_out), b);
      check(addr_out == 12'(ea), "R9 addr", int'(addr_out), ea);
      if (c == 1) begin last_act[b] = gedge; last_any = gedge; open_m[b] = 1; end
      if (c == 4) open_m[b] = 0;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int ga, gr, gp, gb, g1, gw, gx, g;
    int now, exp, c, b;
    int unsigned seed;
    for (int i = 0; i < 4; i++) begin last_act[i] = -1000; open_m[i] = 0; end
    last_any = -1000;

    repeat (3) @(negedge clk);
    check(!grant && cmd_out == 0 && proto_err == 0, "R1 reset outputs", int'(cmd_out), 0);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!grant && cmd_out == 0 && bank_out == 0 && addr_out == 0 && !proto_err,
          "R1 after reset", int'(grant), 0);

    check(RCD_E == 3, "R2 conversion 20ns/7.5ns", RCD_E, 3);

    now = cyc;
    send(1, 0, 12'h5A5, 0, 20, ga);
    check(ga == now + 1, "R10 first ACT immediate", ga, now + 1);
    send(2, 0, 0, 10'h3C, 20, gr);
    check(gr - ga == 3, "R2 R3 ACT to RD gap", gr - ga, 3);
    now = cyc;
    send(4, 0, 0, 0, 20, gp);
    check(gp == now + 1, "R10 PRE immediate", gp, now + 1);
    send(1, 0, 12'h123, 0, 20, gb);
    check(gb - ga == RC_E, "R4 same-bank ACT gap", gb - ga, RC_E);
    send(1, 1, 12'hABC, 0, 20, g1);
    check(g1 - gb == RRD_E, "R5 cross-bank ACT gap", g1 - gb, RRD_E);
    send(3, 1, 0, 10'h2F1, 20, gw);
    check(gw - g1 == RCD_E, "R3 ACT to WR gap", gw - g1, RCD_E);

    send(1, 1, 12'h777, 0, 15, gx);
    check(gx == -1, "R6 ACT to open bank held", gx, -1);
    check(proto_err == 0, "R7 held ACT sets no error", int'(proto_err), 0);
    send(4, 1, 0, 0, 5, g);
    send(1, 1, 12'h777, 0, 20, gx);
    check(gx != -1, "R6 ACT after PRE granted", gx, 1);

    send(0, 2, 0, 0, 5, gx);
    check(gx == -1 && cmd_out == 0, "R8 NOP request not granted", gx, -1);
    send(5, 2, 0, 0, 5, gx);
    check(gx == -1 && cmd_out == 0, "R8 unused code not granted", gx, -1);

    send(2, 3, 0, 5, 6, gx);
    check(gx == -1, "R7 RD to idle bank refused", gx, -1);
    check(proto_err == 1, "R7 error raised", int'(proto_err), 1);
    repeat (3) @(negedge clk);
    check(proto_err == 1, "R7 error sticky", int'(proto_err), 1);

    // modelled sweep over all banks
    seed = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      seed = seed * 1103515245 + 12345;
      b = int'((seed >> 16) % 4);
      if (!open_m[b]) c = 1;
      else c = 2 + int'((seed >> 20) % 3);
      now = cyc;
      exp = now + 1;
      if (c == 1) begin
        if (last_act[b] + RC_E > exp) exp = last_act[b] + RC_E;
        if (last_any + RRD_E > exp) exp = last_any + RRD_E;
      end else if (c == 2 || c == 3) begin
        if (last_act[b] + RCD_E > exp) exp = last_act[b] + RCD_E;
      end
      send(c, b, int'((seed >> 4) & 12'hFFF), int'((seed >> 8) & 10'h3FF), 30, g);
      if (c == 1)      check(g == exp, "R4 R5 sweep ACT edge", g, exp);
      else if (c == 4) check(g == exp, "R10 sweep PRE edge", g, exp);
      else             check(g == exp, "R3 sweep access edge", g, exp);
    end
    check(proto_err == 1, "R7 error held through sweep", int'(proto_err), 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule